// File: doc/BRIEF.md
# Receive Endpoint Buffer Status Controller

This block holds the buffer occupancy and handshake state for sixteen receive endpoints of a full-speed USB device. Index 0 is the control OUT endpoint. Index 1 is the control IN endpoint. Indices 2 to 15 are general endpoints, and each one can be configured as single- or double-buffered. When the bus side reports that a packet has ended, the block returns one registered handshake decision (ACK, NAK or STALL) and updates the flags of that endpoint.

Software uses an 8-bit command strobe. A clear command frees the buffer that the CPU is currently looking at. On a double-buffered endpoint the same command also moves the CPU to the other buffer. A query command returns one status byte on the next cycle and leaves the state unchanged. The one exception is the setup-overwritten flag, which a query consumes.

Packet data storage, bit-level bus handling, CRC checking and the IN data path are outside this block. Stall conditions arrive as a per-endpoint input level.

Top module: `ep_status_ctrl`

## Requirements
- R1: After reset, every endpoint's status byte reads 0x00 (while its stall input is low), and hs_valid and rd_valid are low.
- R2: On a single-buffered endpoint, a data packet arriving when the primary buffer is empty is answered ACK and sets primary-full (status bit 5). Further data packets are answered NAK and change nothing until the buffer is cleared.
- R3: Code 0x70 clears endpoint 0, and codes 0x72 to 0x7F clear endpoints 2 to 15. A clear drops the buffer-full flag of the buffer under CPU access and drops the setup flag. Code 0x71 and any code outside 0x7X and 0xDX change no endpoint state.
- R4: On a double-buffered endpoint, a packet goes into the buffer named by an alternating write pointer, or into the other buffer if that one is full, and the pointer then moves past the buffer just written. NAK is returned only when both buffers are full. A clear frees the buffer selected for CPU access and inverts the CPU select (status bit 1, 0 = primary).
- R5: Code 0xD0+n returns, one cycle later with rd_valid high, the status byte of endpoint n as it stood before that cycle. The layout is: bit 7 stall, bit 6 secondary full, bit 5 primary full, bit 4 next PID (1 = DATA1), bit 3 setup overwritten, bit 2 setup held, bit 1 CPU select, bit 0 always 0. A query changes no other bit.
- R6: A data packet to an endpoint whose stall input is high is answered STALL and leaves that endpoint's flags unchanged.
- R7: A setup packet (bus_setup high) to endpoint 0 is always answered ACK, even when the endpoint is stalled or full. It sets primary-full and setup-held and forces the next PID to DATA1. A setup packet to any other endpoint is handled as a data packet.
- R8: Each data packet answered ACK inverts the next-PID bit of its endpoint.
- R9: The setup-overwritten bit is set when a setup packet arrives while the setup-held flag is still set. A query of that endpoint clears it, except when a bit-setting setup packet lands in the same cycle, in which case the bit stays set.
- R10: If a clear command and a packet reach the same endpoint in the same cycle, the clear takes effect first and the packet is judged against the cleared state.
- R11: hs_valid pulses exactly one cycle after bus_valid. hs_code is 0 for ACK, 1 for NAK and 2 for STALL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dbl | input | 16 | Per-endpoint double-buffer enable (used for indices 2 to 15) |
| ep_stall | input | 16 | Per-endpoint stall level |
| bus_valid | input | 1 | A packet has ended on the bus this cycle |
| bus_setup | input | 1 | The ending packet is a setup packet |
| bus_ep | input | 4 | Endpoint index of the packet |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | Handshake: 0 ACK, 1 NAK, 2 STALL |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| rd_valid | output | 1 | Status byte valid |
| rd_data | output | 8 | Status byte |

## Verification
Two functions can act on the same endpoint in the same cycle. In the first case a clear and a packet arrive together, and the bench drives both strobes on one edge. It expects ACK from a full single-buffered endpoint, and a later query must show the buffer refilled with the PID advanced. In the second case a status query coincides with a setup packet that sets the overwritten bit. The bench issues both together and expects the returned byte to show the state from before that cycle. It then expects the next query to still see bit 3 set, and the query after that to see it cleared.

// File: rtl/ep_status_pkg.sv
package ep_status_pkg;

  typedef enum logic [1:0] {
    HS_ACK   = 2'd0,
    HS_NAK   = 2'd1,
    HS_STALL = 2'd2
  } hs_e;

  typedef struct packed {
    logic full1;
    logic full0;
    logic pid;
    logic ovw;
    logic setup;
    logic cpubuf;
  } ep_state_t;

  localparam logic [3:0] GRP_CLEAR = 4'h7;
  localparam logic [3:0] GRP_QUERY = 4'hD;
  localparam int         CTRL_IN_IDX = 1;

  function automatic logic [7:0] status_byte(input logic stall, input ep_state_t s);
    return {stall, s.full1, s.full0, s.pid, s.ovw, s.setup, s.cpubuf, 1'b0};
  endfunction

endpackage

// File: rtl/ep_cmd_decode.sv
module ep_cmd_decode
  import ep_status_pkg::*;
#(
  parameter int NUM_EP = 16
) (
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  output logic [NUM_EP-1:0] clr_o,
  output logic [NUM_EP-1:0] qry_o
);

  logic is_clr;
  logic is_qry;

  assign is_clr = cmd_valid && (cmd_code[7:4] == GRP_CLEAR);
  assign is_qry = cmd_valid && (cmd_code[7:4] == GRP_QUERY);

  for (genvar g = 0; g < NUM_EP; g++) begin : g_dec
    localparam logic [3:0] IDX = 4'(g);
    if (g == CTRL_IN_IDX) begin : g_noclr
      assign clr_o[g] = 1'b0;
    end else begin : g_clr
      assign clr_o[g] = is_clr && (cmd_code[3:0] == IDX);
    end
    assign qry_o[g] = is_qry && (cmd_code[3:0] == IDX);
  end

endmodule

// File: rtl/ep_slot.sv
module ep_slot
  import ep_status_pkg::*;
#(
  parameter bit SETUP_EP = 1'b0,
  parameter bit DBL_OK   = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      dbl_i,
  input  logic      stall_i,
  input  logic      pkt_i,
  input  logic      setup_i,
  input  logic      clr_i,
  input  logic      rd_i,
  output hs_e       hs_o,
  output ep_state_t st_o
);

  ep_state_t st_q, c, n;
  logic      wrsel_q, n_wr;
  logic      dbl, is_setup, tgt, ovw_set;
  hs_e       hs;

  assign dbl      = DBL_OK && dbl_i;
  assign is_setup = SETUP_EP && setup_i;

  always_comb begin
    c = st_q;
    if (clr_i) begin
      c.setup = 1'b0;
      if (dbl) begin
        if (st_q.cpubuf) c.full1 = 1'b0;
        else             c.full0 = 1'b0;
        c.cpubuf = ~st_q.cpubuf;
      end else begin
        c.full0 = 1'b0;
      end
    end

    hs = HS_ACK;
    if (!is_setup) begin
      if (stall_i)                                     hs = HS_STALL;
      else if (dbl ? (c.full0 && c.full1) : c.full0)   hs = HS_NAK;
    end

    n       = c;
    n_wr    = wrsel_q;
    ovw_set = 1'b0;
    tgt     = dbl && (wrsel_q ? !c.full1 : c.full0);
    if (pkt_i && hs == HS_ACK) begin
      if (is_setup) begin
        n.full0 = 1'b1;
        n.setup = 1'b1;
        n.pid   = 1'b1;
        ovw_set = c.setup;
      end else begin
        if (tgt) n.full1 = 1'b1;
        else     n.full0 = 1'b1;
        if (dbl) n_wr = ~tgt;
        n.pid = ~c.pid;
      end
    end
    n.ovw = (rd_i ? 1'b0 : c.ovw) | ovw_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= '0;
      wrsel_q <= 1'b0;
    end else begin
      st_q    <= n;
      wrsel_q <= n_wr;
    end
  end

  assign hs_o = hs;
  assign st_o = st_q;

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (pkt_i && !is_setup && stall_i && !clr_i) |=> $stable(st_q));

  assert_nak_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (pkt_i && hs_o == HS_NAK && !rd_i) |=> $stable(st_q));

  assert_setup_accept_R7: assert property (@(posedge clk) disable iff (rst)
    (pkt_i && is_setup) |=> (st_q.pid && st_q.setup && st_q.full0));

  assert_ovw_consumed_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !(pkt_i && is_setup)) |=> !st_q.ovw);

endmodule

// File: rtl/ep_status_ctrl.sv
module ep_status_ctrl
  import ep_status_pkg::*;
#(
  parameter int NUM_EP = 16,
  localparam int EPW = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EP-1:0] cfg_dbl,
  input  logic [NUM_EP-1:0] ep_stall,
  input  logic              bus_valid,
  input  logic              bus_setup,
  input  logic [EPW-1:0]    bus_ep,
  output logic              hs_valid,
  output logic [1:0]        hs_code,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);

  logic [NUM_EP-1:0] clr_vec, qry_vec, pkt_vec;
  hs_e               hs_vec [NUM_EP];
  ep_state_t         st_vec [NUM_EP];
  logic [EPW-1:0]    rd_idx;
  logic              qry_any;

  ep_cmd_decode #(.NUM_EP(NUM_EP)) dec_i (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .clr_o     (clr_vec),
    .qry_o     (qry_vec)
  );

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    assign pkt_vec[g] = bus_valid && (bus_ep == EPW'(g));
    ep_slot #(
      .SETUP_EP (g == 0),
      .DBL_OK   (g >= 2)
    ) slot_i (
      .clk     (clk),
      .rst     (rst),
      .dbl_i   (cfg_dbl[g]),
      .stall_i (ep_stall[g]),
      .pkt_i   (pkt_vec[g]),
      .setup_i (bus_setup),
      .clr_i   (clr_vec[g]),
      .rd_i    (qry_vec[g]),
      .hs_o    (hs_vec[g]),
      .st_o    (st_vec[g])
    );
  end

  assign rd_idx  = cmd_code[EPW-1:0];
  assign qry_any = |qry_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_valid <= 1'b0;
      hs_code  <= HS_ACK;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      hs_valid <= bus_valid;
      if (bus_valid) hs_code <= hs_vec[bus_ep];
      rd_valid <= qry_any;
      if (qry_any) rd_data <= status_byte(ep_stall[rd_idx], st_vec[rd_idx]);
    end
  end

  assert_hs_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    bus_valid |=> hs_valid);

  assert_hs_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> !hs_valid);

  assert_query_reply_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code[7:4] == GRP_QUERY) |=> (rd_valid && !rd_data[0]));

endmodule

// File: tb/ep_status_ctrl_tb_top.sv
module ep_status_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 39;

  // {req[3:0], op[1:0], arg[7:0], exp[7:0]}; op 0 bus (arg[7]=setup, arg[3:0]=ep, exp=hs), 1 cmd, 2 query
  localparam logic [21:0] VEC [0:NV-1] = '{
    {4'd2,  2'd0, 8'h02, 8'h00},  // R2 accept into empty ep2
    {4'd2,  2'd2, 8'hD2, 8'h30},  // R2 R8 full, pid DATA1
    {4'd2,  2'd0, 8'h02, 8'h01},  // R2 NAK when full
    {4'd5,  2'd2, 8'hD2, 8'h30},  // R5 query has no side effect
    {4'd3,  2'd1, 8'h72, 8'h00},  // R3 clear ep2
    {4'd3,  2'd2, 8'hD2, 8'h10},
    {4'd8,  2'd0, 8'h02, 8'h00},  // R8
    {4'd8,  2'd2, 8'hD2, 8'h20},
    {4'd4,  2'd0, 8'h03, 8'h00},  // R4 double: primary
    {4'd4,  2'd0, 8'h03, 8'h00},  // R4 secondary
    {4'd4,  2'd2, 8'hD3, 8'h60},
    {4'd4,  2'd0, 8'h03, 8'h01},  // R4 NAK both full
    {4'd4,  2'd1, 8'h73, 8'h00},
    {4'd4,  2'd2, 8'hD3, 8'h42},  // R4 primary freed, select secondary
    {4'd4,  2'd0, 8'h03, 8'h00},
    {4'd4,  2'd2, 8'hD3, 8'h72},
    {4'd4,  2'd1, 8'h73, 8'h00},
    {4'd4,  2'd2, 8'hD3, 8'h30},
    {4'd4,  2'd0, 8'h03, 8'h00},  // R4 alternate into secondary
    {4'd4,  2'd2, 8'hD3, 8'h60},
    {4'd6,  2'd0, 8'h05, 8'h02},  // R6 stalled
    {4'd6,  2'd2, 8'hD5, 8'h80},
    {4'd11, 2'd0, 8'h01, 8'h00},  // R11 ACK code
    {4'd3,  2'd2, 8'hD1, 8'h30},
    {4'd3,  2'd1, 8'h71, 8'h00},  // R3 unused code
    {4'd3,  2'd2, 8'hD1, 8'h30},
    {4'd3,  2'd1, 8'h55, 8'h00},  // R3 foreign code
    {4'd3,  2'd2, 8'hD2, 8'h20},
    {4'd7,  2'd0, 8'h80, 8'h00},  // R7 setup ep0
    {4'd7,  2'd2, 8'hD0, 8'h34},
    {4'd2,  2'd0, 8'h00, 8'h01},  // R2 data NAK on full ep0
    {4'd7,  2'd2, 8'hD0, 8'h34},
    {4'd9,  2'd0, 8'h80, 8'h00},  // R9 second setup overwrites
    {4'd9,  2'd2, 8'hD0, 8'h3C},
    {4'd9,  2'd2, 8'hD0, 8'h34},  // R9 consumed by read
    {4'd3,  2'd1, 8'h70, 8'h00},
    {4'd3,  2'd2, 8'hD0, 8'h10},
    {4'd8,  2'd0, 8'h00, 8'h00},
    {4'd8,  2'd2, 8'hD0, 8'h20}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cfg_dbl, ep_stall;
  logic        bus_valid, bus_setup;
  logic [3:0]  bus_ep;
  logic        hs_valid;
  logic [1:0]  hs_code;
  logic        cmd_valid;
  logic [7:0]  cmd_code;
  logic        rd_valid;
  logic [7:0]  rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_status_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_dbl(cfg_dbl), .ep_stall(ep_stall),
    .bus_valid(bus_valid), .bus_setup(bus_setup), .bus_ep(bus_ep),
    .hs_valid(hs_valid), .hs_code(hs_code),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // drive one cycle of strobes; outputs sampled just after the capturing edge
  task automatic step(input logic bv, input logic bs, input logic [3:0] be,
                      input logic cv, input logic [7:0] cc);
    @(negedge clk);
    bus_valid = bv; bus_setup = bs; bus_ep = be;
    cmd_valid = cv; cmd_code = cc;
    @(posedge clk);
    #1;
    bus_valid = 1'b0; bus_setup = 1'b0; cmd_valid = 1'b0;
  endtask

  task automatic query(input string req, input logic [3:0] ep, input int exp);
    step(1'b0, 1'b0, 4'd0, 1'b1, {4'hD, ep});
    check(req, {31'd0, rd_valid}, 1);
    check(req, int'(rd_data), exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_dbl = 16'h0008; ep_stall = 16'h0000;
    bus_valid = 0; bus_setup = 0; bus_ep = 0; cmd_valid = 0; cmd_code = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check("R1 hs_valid", {31'd0, hs_valid}, 0);
    check("R1 rd_valid", {31'd0, rd_valid}, 0);
    for (int e = 0; e < 16; e++) query("R1 reset status", 4'(e), 0);
    ep_stall = 16'h0020;

    for (int i = 0; i < NV; i++) begin
      logic [3:0] rq;
      logic [1:0] op;
      logic [7:0] arg, ex;
      {rq, op, arg, ex} = VEC[i];
      if (op == 2'd0) begin
        step(1'b1, arg[7], arg[3:0], 1'b0, 8'h00);
        check($sformatf("R11 R%0d vec %0d hs_valid", rq, i), {31'd0, hs_valid}, 1);
        check($sformatf("R%0d vec %0d hs_code", rq, i), {30'd0, hs_code}, int'(ex));
      end else if (op == 2'd1) begin
        step(1'b0, 1'b0, 4'd0, 1'b1, arg);
        check($sformatf("R%0d vec %0d no reply", rq, i), {30'd0, rd_valid, hs_valid}, 0);
      end else begin
        query($sformatf("R%0d vec %0d", rq, i), arg[3:0], int'(ex));
      end
    end

    // R10: clear and packet on full ep2 in one cycle (ep2: primary full, pid 0)
    step(1'b1, 1'b0, 4'd2, 1'b1, 8'h72);
    check("R10 hs", {30'd0, hs_code}, 0);
    query("R10 status", 4'd2, 8'h30);

    // R9: setup coinciding with a query (ep0: primary full, pid 0, no setup)
    step(1'b1, 1'b1, 4'd0, 1'b0, 8'h00);
    query("R9 first setup", 4'd0, 8'h34);
    step(1'b1, 1'b1, 4'd0, 1'b1, 8'hD0);
    check("R9 same-cycle read old", int'(rd_data), 8'h34);
    query("R9 bit kept", 4'd0, 8'h3C);
    query("R9 bit consumed", 4'd0, 8'h34);

    // R7 and R6 on stalled control OUT
    ep_stall = 16'h0021;
    step(1'b1, 1'b1, 4'd0, 1'b0, 8'h00);
    check("R7 setup on stalled ep0", {30'd0, hs_code}, 0);
    step(1'b1, 1'b0, 4'd0, 1'b0, 8'h00);
    check("R6 data on stalled ep0", {30'd0, hs_code}, 2);
    query("R6 R7 stalled status", 4'd0, 8'hBC);

    // R4 single-buffered ep4 ignores nothing: second packet NAK without double enable
    step(1'b1, 1'b0, 4'd4, 1'b0, 8'h00);
    step(1'b1, 1'b0, 4'd4, 1'b0, 8'h00);
    check("R2 ep4 single NAK", {30'd0, hs_code}, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule